// File: doc/BRIEF.md
# Packet DMA Burst Sequencer

The sequencer takes one transfer request for a single channel of a packet DMA engine and breaks it into bus bursts. A request gives a start address, a word count and a direction. Per-direction maximum burst settings and three mode controls decide how large each burst is. The modes are fixed sizing, mixed sizing and split-after-retry.

Before each request, the sequencer checks the fill level of the local buffer. A read waits until there is room for every real word of the burst. A write waits until every real word of the burst is already buffered. The bus side has an address handshake (request/grant) and then one handshake per data beat. During the data phase, the sequencer flags the final beat and any padding beats.

If the bus answers with a retry or a termination, the sequencer restarts the transfer from the first word that did not complete. From then on, for the rest of that transfer, the retry sizing rules apply. A one-cycle completion pulse ends the transfer. A busy flag covers the whole transfer.

Top module: `pdma_burst_seq`

## Requirements
- R1: The maximum burst is M = P×8 when the multiplier input is high, otherwise M = P, where P is the per-direction setting and a setting of 0 counts as 1. In fixed mode (`fixed_i`=1, no abort yet in this transfer), every burst length is the largest of 16, 8, 4, 1 that does not exceed M.
- R2: In fixed mode, when fewer words remain than the burst length, the real words come first. Each beat with index ≥ remaining words has `bus_dummy_o`=1 and does not advance the address. `bus_last_o` is high exactly on beat index length−1.
- R3: In mixed mode (`fixed_i`=0, `mixed_i`=1, no abort yet), let C = min(remaining, M). If C > 16 the burst is one burst of C words. Otherwise the burst is the largest of 16, 8, 4, 1 that does not exceed C.
- R4: With both `fixed_i` and `mixed_i` low and no abort yet, each burst is min(remaining, M) words.
- R5: `bus_abort_i` high during the data phase ends the burst, and the beat in that cycle is not counted. The next request addresses the first unfinished word: start + 4×(words completed).
- R6: After an abort with `retry_split_i`=0, all remaining words go out as one burst of exactly that count, ignoring M. When one word remains, this gives a single one-word burst, and the transfer completes right after it.
- R7: After an abort with `retry_split_i`=1, each burst is the largest of 16, 8, 4, 1 not above min(remaining, M), with no padding.
- R8: A read burst (`dir_wr_i`=0) is requested only when `buf_space_i` ≥ its real word count. A write burst (`dir_wr_i`=1) is requested only when `buf_data_i` ≥ its real word count. `bus_req_o`, `bus_addr_o` and `bus_len_o` hold steady until `bus_gnt_i`.
- R9: Reads use `rd_pbl_i` and writes use `wr_pbl_i`. The direction is taken at start.
- R10: `busy_o` rises in the cycle after an accepted start and falls together with a one-cycle `done_o`. `done_o` comes the cycle after the beat that finishes the last word.
- R11: During and right after reset, `bus_req_o`, `busy_o` and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse; taken only when idle and the count is non-zero |
| dir_wr_i | input | 1 | 1 = bus write from local buffer, 0 = bus read into buffer |
| start_addr_i | input | ADDR_W | Byte address of the first word |
| word_cnt_i | input | CNT_W | Number of words to transfer |
| rd_pbl_i | input | PBL_W | Maximum burst setting for reads |
| wr_pbl_i | input | PBL_W | Maximum burst setting for writes |
| pbl_x8_i | input | 1 | Multiplies the selected setting by 8 |
| fixed_i | input | 1 | Fixed burst sizing with padding |
| mixed_i | input | 1 | Mixed sizing (when fixed is low) |
| retry_split_i | input | 1 | Split the leftover words into set sizes after an abort |
| buf_space_i | input | LVL_W | Free words in the local buffer |
| buf_data_i | input | LVL_W | Buffered words ready to write |
| bus_req_o | output | 1 | Burst request |
| bus_gnt_i | input | 1 | Burst grant |
| bus_addr_o | output | ADDR_W | Burst address (current word during data phase) |
| bus_len_o | output | CNT_W | Burst length in beats |
| bus_beat_i | input | 1 | One data beat completes |
| bus_abort_i | input | 1 | Retry or termination response |
| bus_last_o | output | 1 | Current beat is the final one of the burst |
| bus_dummy_o | output | 1 | Current beat is padding |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The hardest situation to reach is an abort part-way through a burst. After it, the sizing rules change for the rest of the transfer, and the restart address depends on exactly which beat carried the abort. The bench responder drives data beats itself and can raise the abort on any chosen beat index, with the beat strobe also high in that cycle. That lets the bench check both the discarded beat and the sizing of the leftover words, in the split and unsplit variants and for the single-word remainder. The buffer-level gating is reached by holding the reported level one word short for several cycles before raising it.

// File: rtl/pdma_pkg.sv
// Shared definitions for the packet DMA burst sequencer.
package pdma_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PLAN,
        ST_HOLD,
        ST_REQ,
        ST_DATA
    } seq_state_e;
endpackage

// File: rtl/pdma_size_pick.sv
// Burst length selector.
// What it does: from the remaining word count, the maximum burst and the
// mode controls, computes the burst length and how many of its beats carry
// real data.
// Assumes: rem_i > 0, max_i > 0, CNT_W >= 5.
module pdma_size_pick #(
    parameter int CNT_W = 16,
    parameter int ML_W  = 9
) (
    input  logic [CNT_W-1:0] rem_i,
    input  logic [ML_W-1:0]  max_i,
    input  logic             fixed_i,
    input  logic             mixed_i,
    input  logic             retry_i,
    input  logic             split_i,
    output logic [CNT_W-1:0] len_o,
    output logic [CNT_W-1:0] real_o
);
    localparam int W = (CNT_W > ML_W) ? CNT_W : ML_W;

    logic [W-1:0] rem_w, max_w, cap_w, len_w, real_w;

    // Largest member of the fixed size set not above lim.
    function automatic logic [W-1:0] fit(input logic [W-1:0] lim);
        if (lim >= W'(16))     return W'(16);
        else if (lim >= W'(8)) return W'(8);
        else if (lim >= W'(4)) return W'(4);
        else                   return W'(1);
    endfunction

    // Widen the inputs and form the capped length.
    always_comb begin
        rem_w = W'(rem_i);
        max_w = W'(max_i);
        cap_w = (rem_w < max_w) ? rem_w : max_w;
    end

    // Choose the burst length according to the active rule.
    always_comb begin
        if (retry_i) begin
            len_w  = split_i ? fit(cap_w) : rem_w;
            real_w = len_w;
        end else if (fixed_i) begin
            len_w  = fit(max_w);
            real_w = (rem_w < len_w) ? rem_w : len_w;
        end else if (mixed_i) begin
            len_w  = (cap_w > W'(16)) ? cap_w : fit(cap_w);
            real_w = len_w;
        end else begin
            len_w  = cap_w;
            real_w = len_w;
        end
    end

    assign len_o  = CNT_W'(len_w);
    assign real_o = CNT_W'(real_w);
endmodule

// File: rtl/pdma_level_gate.sv
// Buffer level gate.
// What it does: reports whether the local buffer can serve a burst of need_i
// real words in the given direction.
// Assumes: level inputs are current for the cycle they are sampled.
module pdma_level_gate #(
    parameter int CNT_W = 16,
    parameter int LVL_W = 8
) (
    input  logic             is_write_i,
    input  logic [LVL_W-1:0] space_i,
    input  logic [LVL_W-1:0] data_i,
    input  logic [CNT_W-1:0] need_i,
    output logic             ok_o
);
    localparam int W = (CNT_W > LVL_W) ? CNT_W : LVL_W;

    // Compare the relevant level against the real word count.
    always_comb begin
        if (is_write_i) ok_o = W'(data_i)  >= W'(need_i);
        else            ok_o = W'(space_i) >= W'(need_i);
    end
endmodule

// File: rtl/pdma_burst_seq.sv
// Packet DMA burst sequencer (top).
// What it does: splits one transfer into bursts, gates each request on the
// buffer level, runs the data beats, pads in fixed mode, and restarts the
// transfer at the first unfinished word after an abort.
// Assumes: mode and level inputs are held steady while a burst is planned.
// Assumes: bus_beat_i/bus_abort_i matter only in the data phase.
// Assumes: addresses advance by WORD_BYTES per real word.
module pdma_burst_seq #(
    parameter int ADDR_W     = 32,
    parameter int CNT_W      = 16,
    parameter int PBL_W      = 6,
    parameter int LVL_W      = 8,
    parameter int WORD_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              dir_wr_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    input  logic [CNT_W-1:0]  word_cnt_i,
    input  logic [PBL_W-1:0]  rd_pbl_i,
    input  logic [PBL_W-1:0]  wr_pbl_i,
    input  logic              pbl_x8_i,
    input  logic              fixed_i,
    input  logic              mixed_i,
    input  logic              retry_split_i,
    input  logic [LVL_W-1:0]  buf_space_i,
    input  logic [LVL_W-1:0]  buf_data_i,
    output logic              bus_req_o,
    input  logic              bus_gnt_i,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [CNT_W-1:0]  bus_len_o,
    input  logic              bus_beat_i,
    input  logic              bus_abort_i,
    output logic              bus_last_o,
    output logic              bus_dummy_o,
    output logic              busy_o,
    output logic              done_o
);
    import pdma_pkg::*;

    localparam int ML_W = PBL_W + 3;

    seq_state_e        state_q;
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  rem_q, len_q, real_q, beat_q;
    logic              dir_q, retry_q, done_q;

    logic [PBL_W-1:0]  pbl_sel;
    logic [ML_W-1:0]   max_len;
    logic [CNT_W-1:0]  pick_len, pick_real, rem_after;
    logic              lvl_ok, beat_real, beat_final;

    // Maximum burst from the setting of the latched direction.
    always_comb begin
        pbl_sel = dir_q ? wr_pbl_i : rd_pbl_i;
        max_len = (pbl_sel == '0) ? ML_W'(1) : ML_W'(pbl_sel);
        if (pbl_x8_i) max_len = max_len << 3;
    end

    pdma_size_pick #(.CNT_W(CNT_W), .ML_W(ML_W)) i_pick (
        .rem_i   (rem_q),
        .max_i   (max_len),
        .fixed_i (fixed_i),
        .mixed_i (mixed_i),
        .retry_i (retry_q),
        .split_i (retry_split_i),
        .len_o   (pick_len),
        .real_o  (pick_real)
    );

    pdma_level_gate #(.CNT_W(CNT_W), .LVL_W(LVL_W)) i_gate (
        .is_write_i (dir_q),
        .space_i    (buf_space_i),
        .data_i     (buf_data_i),
        .need_i     (real_q),
        .ok_o       (lvl_ok)
    );

    // Beat classification within the current burst.
    always_comb begin
        beat_real  = beat_q < real_q;
        beat_final = beat_q == (len_q - CNT_W'(1));
        rem_after  = beat_real ? (rem_q - CNT_W'(1)) : rem_q;
    end

    // Sequencer state, counters and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            rem_q   <= '0;
            len_q   <= '0;
            real_q  <= '0;
            beat_q  <= '0;
            dir_q   <= 1'b0;
            retry_q <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_i && (word_cnt_i != '0)) begin
                        addr_q  <= start_addr_i;
                        rem_q   <= word_cnt_i;
                        dir_q   <= dir_wr_i;
                        retry_q <= 1'b0;
                        state_q <= ST_PLAN;
                    end
                end
                ST_PLAN: begin
                    len_q   <= pick_len;
                    real_q  <= pick_real;
                    state_q <= ST_HOLD;
                end
                ST_HOLD: begin
                    if (lvl_ok) state_q <= ST_REQ;
                end
                ST_REQ: begin
                    if (bus_gnt_i) begin
                        beat_q  <= '0;
                        state_q <= ST_DATA;
                    end
                end
                ST_DATA: begin
                    if (bus_abort_i) begin
                        retry_q <= 1'b1;
                        if (rem_q == '0) begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                        end else begin
                            state_q <= ST_PLAN;
                        end
                    end else if (bus_beat_i) begin
                        if (beat_real) begin
                            rem_q  <= rem_after;
                            addr_q <= addr_q + ADDR_W'(WORD_BYTES);
                        end
                        beat_q <= beat_q + CNT_W'(1);
                        if (beat_final) begin
                            if (rem_after == '0) begin
                                state_q <= ST_IDLE;
                                done_q  <= 1'b1;
                            end else begin
                                state_q <= ST_PLAN;
                            end
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Bus and status outputs.
    always_comb begin
        bus_req_o   = state_q == ST_REQ;
        bus_addr_o  = addr_q;
        bus_len_o   = len_q;
        bus_last_o  = (state_q == ST_DATA) && beat_final;
        bus_dummy_o = (state_q == ST_DATA) && !beat_real;
        busy_o      = state_q != ST_IDLE;
        done_o      = done_q;
    end
endmodule

// File: rtl/pdma_burst_seq_chk.sv
// Protocol checker for the burst sequencer, attached by bind.
// What it does: watches the port-level handshake and status rules.
// Assumes: synchronous active-low reset on rst_n.
module pdma_burst_seq_chk #(
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_req_o,
    input logic              bus_gnt_i,
    input logic [ADDR_W-1:0] bus_addr_o,
    input logic [CNT_W-1:0]  bus_len_o,
    input logic              bus_beat_i,
    input logic              bus_abort_i,
    input logic              bus_last_o,
    input logic              bus_dummy_o,
    input logic              busy_o,
    input logic              done_o
);
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_o && !bus_gnt_i |=> bus_req_o); // R8
    AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_o && !bus_gnt_i |=> $stable(bus_addr_o) && $stable(bus_len_o)); // R8
    AST_LEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_o |-> bus_len_o != '0); // R1
    AST_PAD_NO_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_dummy_o && bus_beat_i && !bus_abort_i |=> $stable(bus_addr_o)); // R2
    AST_REQ_LAST_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bus_req_o, bus_last_o})); // R2
    AST_ABORT_ENDS_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        bus_abort_i && (bus_last_o || bus_dummy_o) |=> !bus_last_o && !bus_dummy_o); // R5
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R10
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o); // R10
    AST_REQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_o |-> busy_o); // R10
endmodule

bind pdma_burst_seq pdma_burst_seq_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_req_o   (bus_req_o),
    .bus_gnt_i   (bus_gnt_i),
    .bus_addr_o  (bus_addr_o),
    .bus_len_o   (bus_len_o),
    .bus_beat_i  (bus_beat_i),
    .bus_abort_i (bus_abort_i),
    .bus_last_o  (bus_last_o),
    .bus_dummy_o (bus_dummy_o),
    .busy_o      (busy_o),
    .done_o      (done_o)
);

// File: tb/test_pdma_burst_seq.sv
// Scoreboard bench: the driver queues expected bursts, and the monitor grants,
// serves the beats and compares.
module test_pdma_burst_seq;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [31:0] addr;
        int          len;
        int          nreal;
    } burst_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0, dir_wr_i = 1'b0;
    logic [31:0] start_addr_i = '0;
    logic [15:0] word_cnt_i = '0;
    logic [5:0]  rd_pbl_i = 6'd1, wr_pbl_i = 6'd1;
    logic        pbl_x8_i = 1'b0, fixed_i = 1'b0, mixed_i = 1'b0, retry_split_i = 1'b0;
    logic [7:0]  buf_space_i = 8'd255, buf_data_i = 8'd255;
    logic        bus_gnt_i = 1'b0, bus_beat_i = 1'b0, bus_abort_i = 1'b0;
    logic        bus_req_o, bus_last_o, bus_dummy_o, busy_o, done_o;
    logic [31:0] bus_addr_o;
    logic [15:0] bus_len_o;

    int     n_chk = 0, n_err = 0;
    int     abort_at = -1;
    burst_t exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    pdma_burst_seq i_pdma_burst_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .dir_wr_i(dir_wr_i),
        .start_addr_i(start_addr_i), .word_cnt_i(word_cnt_i),
        .rd_pbl_i(rd_pbl_i), .wr_pbl_i(wr_pbl_i), .pbl_x8_i(pbl_x8_i),
        .fixed_i(fixed_i), .mixed_i(mixed_i), .retry_split_i(retry_split_i),
        .buf_space_i(buf_space_i), .buf_data_i(buf_data_i),
        .bus_req_o(bus_req_o), .bus_gnt_i(bus_gnt_i), .bus_addr_o(bus_addr_o),
        .bus_len_o(bus_len_o), .bus_beat_i(bus_beat_i), .bus_abort_i(bus_abort_i),
        .bus_last_o(bus_last_o), .bus_dummy_o(bus_dummy_o),
        .busy_o(busy_o), .done_o(done_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic push(input logic [31:0] a, input int len, input int nr);
        burst_t b;
        b.addr = a; b.len = len; b.nreal = nr;
        exp_q.push_back(b);
    endtask

    task automatic cfg(input logic fx, input logic mx, input logic sp,
                       input logic [5:0] rp, input logic [5:0] wp, input logic x8);
        fixed_i = fx; mixed_i = mx; retry_split_i = sp;
        rd_pbl_i = rp; wr_pbl_i = wp; pbl_x8_i = x8;
    endtask

    task automatic kick(input logic w, input logic [31:0] a, input int n);
        @(negedge clk);
        dir_wr_i = w; start_addr_i = a; word_cnt_i = 16'(n); start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o == 1'b1, "R10", "busy after start", longint'(busy_o), 1);
    endtask

    task automatic finish_xfer(input string req);
        int waited = 0;
        while (!done_o && waited < 3000) begin
            @(negedge clk);
            waited++;
        end
        chk(done_o == 1'b1, "R10", "done pulse seen", longint'(done_o), 1);
        chk(busy_o == 1'b0, "R10", "busy low at done", longint'(busy_o), 0);
        chk(exp_q.size() == 0, req, "bursts left unissued", exp_q.size(), 0);
        @(negedge clk);
        chk(done_o == 1'b0, "R10", "done width", longint'(done_o), 0);
        exp_q.delete();
    endtask

    // Monitor: grant requests, compare with the queue, serve beats.
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && bus_req_o) begin
                burst_t b;
                int     ab;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R8", "unexpected burst len", longint'(bus_len_o), 0);
                    b.addr = bus_addr_o; b.len = int'(bus_len_o); b.nreal = b.len;
                end else begin
                    b = exp_q.pop_front();
                    chk(bus_addr_o == b.addr, "R5", "burst addr", longint'(bus_addr_o), longint'(b.addr));
                    chk(int'(bus_len_o) == b.len, "R1", "burst len", longint'(bus_len_o), b.len);
                end
                ab = abort_at;
                abort_at = -1;
                bus_gnt_i = 1'b1;
                @(negedge clk);
                bus_gnt_i = 1'b0;
                for (int i = 0; i < b.len; i++) begin
                    bus_beat_i = 1'b1;
                    bus_abort_i = (i == ab);
                    chk(bus_dummy_o == (i >= b.nreal), "R2", "dummy flag", longint'(bus_dummy_o), longint'(i >= b.nreal));
                    chk(bus_last_o == (i == b.len - 1), "R2", "last flag", longint'(bus_last_o), longint'(i == b.len - 1));
                    @(negedge clk);
                    bus_beat_i = 1'b0;
                    bus_abort_i = 1'b0;
                    if (i == ab) break;
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL R10 watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(bus_req_o == 1'b0, "R11", "req in reset", longint'(bus_req_o), 0);
        chk(busy_o == 1'b0, "R11", "busy in reset", longint'(busy_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(done_o == 1'b0, "R11", "done after reset", longint'(done_o), 0);
        chk(busy_o == 1'b0, "R11", "busy after reset", longint'(busy_o), 0);

        // R1 R2: fixed mode, max 8, ten words -> 8 + 8 with six pads
        cfg(1, 0, 0, 6'd8, 6'd1, 0);
        push(32'h1000, 8, 8); push(32'h1020, 8, 2);
        kick(0, 32'h1000, 10); finish_xfer("R2");

        // R1: setting 5 fits to 4
        cfg(1, 0, 0, 6'd5, 6'd1, 0);
        push(32'h1100, 4, 4); push(32'h1110, 4, 2);
        kick(0, 32'h1100, 6); finish_xfer("R1");

        // R3 R9: mixed write, wr setting 4 x8 = 32
        cfg(0, 1, 0, 6'd1, 6'd4, 1);
        push(32'h2000, 32, 32); push(32'h2080, 8, 8); push(32'h20A0, 4, 4); push(32'h20B0, 1, 1);
        kick(1, 32'h2000, 45); finish_xfer("R3");

        // R9: read uses rd setting 2 x8 = 16 while wr setting is 1
        cfg(1, 0, 0, 6'd2, 6'd1, 1);
        push(32'h2800, 16, 16);
        kick(0, 32'h2800, 16); finish_xfer("R9");

        // R4: plain sizing, max 6
        cfg(0, 0, 0, 6'd6, 6'd1, 0);
        push(32'h3000, 6, 6); push(32'h3018, 6, 6); push(32'h3030, 2, 2);
        kick(0, 32'h3000, 14); finish_xfer("R4");

        // R5 R6: abort on beat 5, leftovers in one burst
        cfg(0, 1, 0, 6'd16, 6'd1, 0);
        abort_at = 5;
        push(32'h4000, 16, 16); push(32'h4014, 15, 15);
        kick(0, 32'h4000, 20); finish_xfer("R6");

        // R7: abort on beat 3, leftovers split into set sizes
        cfg(0, 1, 1, 6'd16, 6'd1, 0);
        abort_at = 3;
        push(32'h5000, 16, 16); push(32'h500C, 16, 16); push(32'h504C, 1, 1);
        kick(0, 32'h5000, 20); finish_xfer("R7");

        // R6: abort leaving one word -> single-word burst and completion
        cfg(0, 0, 0, 6'd4, 6'd1, 0);
        abort_at = 3;
        push(32'h6000, 4, 4); push(32'h600C, 1, 1);
        kick(0, 32'h6000, 4); finish_xfer("R6");

        // R8: read waits for space of 8
        cfg(1, 0, 0, 6'd8, 6'd1, 0);
        buf_space_i = 8'd7;
        push(32'h7000, 8, 8);
        kick(0, 32'h7000, 8);
        repeat (8) @(negedge clk);
        chk(bus_req_o == 1'b0, "R8", "read held for space", longint'(bus_req_o), 0);
        buf_space_i = 8'd8;
        finish_xfer("R8");
        buf_space_i = 8'd255;

        // R8: write waits for 4 buffered words
        cfg(1, 0, 0, 6'd1, 6'd4, 0);
        buf_data_i = 8'd3;
        push(32'h7100, 4, 4);
        kick(1, 32'h7100, 4);
        repeat (8) @(negedge clk);
        chk(bus_req_o == 1'b0, "R8", "write held for data", longint'(bus_req_o), 0);
        buf_data_i = 8'd4;
        finish_xfer("R8");
        buf_data_i = 8'd255;

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule